// File: doc/BRIEF.md
# Pulse Record Word Streamer

This block takes one captured pulse record and hands it to a processor one 32-bit word at a time. A record holds a leading-edge timestamp and a trailing-edge timestamp for each of the comparator thresholds, plus the number of thresholds the pulse actually crossed. Each timestamp is 64 bits wide. Only the crossed thresholds are streamed, and each one yields four words.

The processor paces the transfer with a level handshake. While words of the current pulse remain, `have_data` stays high and the current word is held steady on `word_out`. After reading a word, the processor raises `pump` to step to the next word, then lowers it. Raising `pump` on the last word moves nothing. Lowering it afterwards ends the record and drops `have_data`. The `pump` input comes from software and has no fixed timing relation to the clock, so it passes through a two-flop synchroniser before its edges are detected.

A run control freezes the streamer while it is low. The upstream buffer's full flag is passed straight out, so software can see that pulses may be getting lost.

Top module: `pulse_word_streamer`

## Requirements
- R1: After reset, `have_data` is 0 and `word_out` is 0.
- R2: If `rec_valid` is high at a clock edge while `have_data` is low, `run_en` is high and `rec_count` is nonzero, the record is loaded at that edge. From that edge on, `have_data` is 1 and `word_out` shows the upper 32 bits of the threshold-0 leading-edge timestamp.
- R3: Threshold k occupies bits [k*64 +: 64] of `rec_lead` and of `rec_trail`. Thresholds are sent in ascending order from 0. Each threshold sends four words in this order: leading high half, leading low half, trailing high half, trailing low half.
- R4: A record carries exactly 4*`rec_count` words. A count above 6 is treated as 6. A count of 0 loads nothing.
- R5: A rising edge on `pump` changes `word_out` at the third rising clock edge after `pump` goes high. At any other time `word_out` holds its value.
- R6: While the last word is shown, a rising edge on `pump` leaves `word_out` and `have_data` unchanged. `have_data` then falls at the third clock edge after `pump` goes low.
- R7: A record offered while `have_data` is high is ignored, and the current stream continues unchanged.
- R8: While `run_en` is 0, `word_out` and `have_data` hold their values. Pump edges seen during that time are discarded, and no record is loaded.
- R9: `data_lost` follows `buf_full` combinationally.
- R10: `word_out` is 0 whenever `have_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | 1 = run, 0 = pause |
| rec_valid | input | 1 | Offers a record for loading |
| rec_count | input | 3 | Number of thresholds crossed |
| rec_lead | input | 384 | Leading-edge timestamps, 64 bits per threshold |
| rec_trail | input | 384 | Trailing-edge timestamps, 64 bits per threshold |
| pump | input | 1 | Processor step request (asynchronous level) |
| buf_full | input | 1 | Upstream buffer full flag |
| word_out | output | 32 | Current data word |
| have_data | output | 1 | Words of the current pulse remain |
| data_lost | output | 1 | Mirror of `buf_full` |

## Verification
The bench streams records with every crossing count from 1 to 6 and then one record with an out-of-range count. Each word carries its threshold and half-word position, so a wrong order, a wrong half or a wrong word count shows up as a miscompare.

The first step of every record is sampled both one clock edge before and at the expected update edge, which separates correct synchroniser latency from an early or late advance. Separate scenarios cover a pump pulse during pause, a record offered while busy, and a zero count. Each of these is told apart from correct behaviour by observing the held word and `have_data` afterwards.

// File: rtl/psw_pkg.sv
// Package: shared types for the pulse record word streamer.
// Assumes each timestamp is exactly two data words wide.
package psw_pkg;

    // Position of a word within one threshold's group of four.
    typedef enum logic [1:0] {
        SEL_LEAD_HI  = 2'd0,
        SEL_LEAD_LO  = 2'd1,
        SEL_TRAIL_HI = 2'd2,
        SEL_TRAIL_LO = 2'd3
    } word_sel_e;

    localparam int unsigned WORDS_PER_THR = 4;

endpackage

// File: rtl/psw_pump_sync.sv
// Module: psw_pump_sync
// Brings the asynchronous pump level into the clock domain through a chain
// of STAGES flops, then flags a rising edge of the synchronised level.
// Assumes STAGES >= 2.
module psw_pump_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pump_in,
    output logic pump_lvl,
    output logic pump_rise
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // First synchroniser flop samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pump_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage resamples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= 1'b0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Expose the level and its rising edge.
    always_comb begin
        pump_lvl  = chain_q[STAGES-1];
        pump_rise = chain_q[STAGES-1] & ~prev_q;
    end

endmodule

// File: rtl/psw_record_store.sv
// Module: psw_record_store
// Holds the timestamps of one pulse record and selects one data word by
// index: the upper bits pick the threshold, the low two bits pick the part.
// Assumes TS_W == 2*WORD_W.
module psw_record_store
    import psw_pkg::*;
#(
    parameter int unsigned NUM_THR = 6,
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned IDX_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [NUM_THR*2*WORD_W-1:0] lead_in,
    input  logic [NUM_THR*2*WORD_W-1:0] trail_in,
    input  logic [IDX_W-1:0]          idx,
    output logic [WORD_W-1:0]         word
);

    localparam int unsigned TS_W  = 2 * WORD_W;
    localparam int unsigned THR_W = IDX_W - 2;

    logic [TS_W-1:0] lead_q  [NUM_THR];
    logic [TS_W-1:0] trail_q [NUM_THR];
    word_sel_e       part;
    logic [THR_W-1:0] thr;

    generate
        for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
            // Capture this threshold's two timestamps on load.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lead_q[k]  <= '0;
                    trail_q[k] <= '0;
                end else if (load) begin
                    lead_q[k]  <= lead_in[k*TS_W +: TS_W];
                    trail_q[k] <= trail_in[k*TS_W +: TS_W];
                end
            end
        end
    endgenerate

    // Split the index into threshold and part.
    always_comb begin
        part = word_sel_e'(idx[1:0]);
        thr  = idx[IDX_W-1:2];
    end

    // Select the addressed half of the addressed timestamp.
    always_comb begin
        word = '0;
        for (int k = 0; k < NUM_THR; k++) begin
            if (thr == THR_W'(k)) begin
                case (part)
                    SEL_LEAD_HI:  word = lead_q[k][TS_W-1:WORD_W];
                    SEL_LEAD_LO:  word = lead_q[k][WORD_W-1:0];
                    SEL_TRAIL_HI: word = trail_q[k][TS_W-1:WORD_W];
                    default:      word = trail_q[k][WORD_W-1:0];
                endcase
            end
        end
    end

endmodule

// File: rtl/psw_seq_ctrl.sv
// Module: psw_seq_ctrl
// Sequences one record. It accepts a load only while idle and running,
// steps the word index on each pump rise, and marks the last word as
// drained. It releases have_data once the synchronised pump is low.
// The whole state is frozen while run_en is low.
module psw_seq_ctrl #(
    parameter int unsigned NUM_THR = 6,
    parameter int unsigned CNT_W   = 3,
    parameter int unsigned IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             rec_valid,
    input  logic [CNT_W-1:0] rec_count,
    input  logic             pump_rise,
    input  logic             pump_lvl,
    output logic             load,
    output logic             have_data,
    output logic [IDX_W-1:0] idx
);

    logic [CNT_W-1:0] cnt_eff;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] idx_q;
    logic             have_q;
    logic             drained_q;

    // Clamp the crossing count and decide whether a load happens.
    always_comb begin
        cnt_eff = (rec_count > CNT_W'(NUM_THR)) ? CNT_W'(NUM_THR) : rec_count;
        load    = run_en && rec_valid && !have_q && (rec_count != '0);
    end

    // Main sequencing state: load, step, drain, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q    <= 1'b0;
            drained_q <= 1'b0;
            idx_q     <= '0;
            last_q    <= '0;
        end else if (run_en) begin
            if (load) begin
                have_q    <= 1'b1;
                drained_q <= 1'b0;
                idx_q     <= '0;
                last_q    <= (IDX_W'(cnt_eff) << 2) - IDX_W'(1);
            end else if (have_q) begin
                if (pump_rise && !drained_q) begin
                    if (idx_q == last_q) drained_q <= 1'b1;
                    else                 idx_q     <= idx_q + IDX_W'(1);
                end else if (drained_q && !pump_lvl) begin
                    have_q    <= 1'b0;
                    drained_q <= 1'b0;
                end
            end
        end
    end

    // Drive the outputs from state.
    always_comb begin
        have_data = have_q;
        idx       = idx_q;
    end

endmodule

// File: rtl/pulse_word_streamer.sv
// Module: pulse_word_streamer (top)
// Streams the crossed thresholds of one pulse record as 32-bit words under
// a processor-paced pump handshake. Assumes rec_lead and rec_trail stay
// valid during the cycle in which rec_valid is seen.
module pulse_word_streamer #(
    parameter int unsigned NUM_THR     = 6,
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = $clog2(NUM_THR + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_en,
    input  logic                        rec_valid,
    input  logic [CNT_W-1:0]            rec_count,
    input  logic [NUM_THR*2*WORD_W-1:0] rec_lead,
    input  logic [NUM_THR*2*WORD_W-1:0] rec_trail,
    input  logic                        pump,
    input  logic                        buf_full,
    output logic [WORD_W-1:0]           word_out,
    output logic                        have_data,
    output logic                        data_lost
);

    localparam int unsigned IDX_W = $clog2(NUM_THR * psw_pkg::WORDS_PER_THR);

    logic             pump_lvl;
    logic             pump_rise;
    logic             load;
    logic [IDX_W-1:0] idx;
    logic [WORD_W-1:0] sel_word;

    psw_pump_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pump_in   (pump),
        .pump_lvl  (pump_lvl),
        .pump_rise (pump_rise)
    );

    psw_seq_ctrl #(.NUM_THR(NUM_THR), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .rec_valid (rec_valid),
        .rec_count (rec_count),
        .pump_rise (pump_rise),
        .pump_lvl  (pump_lvl),
        .load      (load),
        .have_data (have_data),
        .idx       (idx)
    );

    psw_record_store #(.NUM_THR(NUM_THR), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .lead_in  (rec_lead),
        .trail_in (rec_trail),
        .idx      (idx),
        .word     (sel_word)
    );

    // Gate the data word when idle and mirror the buffer-full flag.
    always_comb begin
        word_out  = have_data ? sel_word : '0;
        data_lost = buf_full;
    end

endmodule

// File: rtl/pulse_word_streamer_chk.sv
// Module: pulse_word_streamer_chk
// Assertion checker bound to the top; it observes ports and the
// synchroniser outputs.
module pulse_word_streamer_chk #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              rec_valid,
    input logic [CNT_W-1:0]  rec_count,
    input logic [WORD_W-1:0] word_out,
    input logic              have_data,
    input logic              pump_rise,
    input logic              pump_lvl
);

    // R2
    load_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(have_data) |-> ($past(rec_valid) && $past(run_en)));

    // R4
    nonzero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(have_data) |-> ($past(rec_count) != '0));

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (have_data && !pump_rise) |=> (!have_data || $stable(word_out)));

    // R6
    release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(have_data) |-> (!$past(pump_lvl) && $past(run_en)));

    // R8
    pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(word_out) && $stable(have_data)));

endmodule

bind pulse_word_streamer pulse_word_streamer_chk #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .rec_valid (rec_valid),
    .rec_count (rec_count),
    .word_out  (word_out),
    .have_data (have_data),
    .pump_rise (pump_rise),
    .pump_lvl  (pump_lvl)
);

// File: tb/pulse_word_streamer_tb.sv
// Directed bench for pulse_word_streamer: one task per scenario.
module pulse_word_streamer_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b1;
    logic         rec_valid = 1'b0;
    logic [2:0]   rec_count = '0;
    logic [383:0] rec_lead = '0;
    logic [383:0] rec_trail = '0;
    logic         pump = 1'b0;
    logic         buf_full = 1'b0;
    logic [31:0]  word_out;
    logic         have_data;
    logic         data_lost;

    logic [383:0] exp_lead;
    logic [383:0] exp_trail;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    pulse_word_streamer u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .rec_valid(rec_valid),
        .rec_count(rec_count), .rec_lead(rec_lead), .rec_trail(rec_trail),
        .pump(pump), .buf_full(buf_full), .word_out(word_out),
        .have_data(have_data), .data_lost(data_lost)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected word i from the bench's own record copy (R3 layout).
    function automatic logic [31:0] exp_word(input int i);
        int k = i / 4;
        case (i % 4)
            0: return exp_lead[k*64+32 +: 32];
            1: return exp_lead[k*64 +: 32];
            2: return exp_trail[k*64+32 +: 32];
            default: return exp_trail[k*64 +: 32];
        endcase
    endfunction

    task automatic make_record(input int seed);
        for (int k = 0; k < 6; k++) begin
            exp_lead[k*64 +: 64]  = {8'hA0, 8'(seed), 8'(k), 8'h1, 8'hB0, 8'(seed), 8'(k), 8'h2};
            exp_trail[k*64 +: 64] = {8'hC0, 8'(seed), 8'(k), 8'h3, 8'hD0, 8'(seed), 8'(k), 8'h4};
        end
    endtask

    task automatic load_rec(input logic [2:0] cnt);
        rec_lead = exp_lead; rec_trail = exp_trail; rec_count = cnt;
        rec_valid = 1'b1;
        tick(1);
        rec_valid = 1'b0;
        chk("R2 have_data after load", 32'(have_data), 32'd1);
        chk("R2 first word", word_out, exp_word(0));
    endtask

    // Step to word i; check it is unchanged before the third edge and updated at it.
    task automatic pump_step(input int i);
        pump = 1'b1;
        tick(2);
        chk("R5 no early advance", word_out, exp_word(i - 1));
        tick(1);
        chk("R3 word order", word_out, exp_word(i));
        pump = 1'b0;
        tick(4);
    endtask

    task automatic drain(input int last);
        pump = 1'b1;
        tick(4);
        chk("R6 last word held", word_out, exp_word(last));
        chk("R6 have_data held", 32'(have_data), 32'd1);
        pump = 1'b0;
        tick(2);
        chk("R6 have_data before release", 32'(have_data), 32'd1);
        tick(1);
        chk("R6 have_data released", 32'(have_data), 32'd0);
        chk("R10 idle word zero", word_out, 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 have_data reset", 32'(have_data), 32'd0);
        chk("R1 word reset", word_out, 32'd0);
    endtask

    task automatic t_stream(input logic [2:0] cnt, input int seed);
        int n = 4 * ((cnt > 3'd6) ? 6 : int'(cnt));
        make_record(seed);
        load_rec(cnt);
        for (int i = 1; i < n; i++) pump_step(i);
        drain(n - 1);   // R4 word count
    endtask

    task automatic t_zero();
        make_record(9);
        rec_lead = exp_lead; rec_count = 3'd0; rec_valid = 1'b1;
        tick(1);
        rec_valid = 1'b0;
        tick(2);
        chk("R4 zero count not loaded", 32'(have_data), 32'd0);
    endtask

    task automatic t_busy();
        make_record(33);
        load_rec(3'd1);
        rec_lead = ~exp_lead; rec_trail = ~exp_trail; rec_count = 3'd3;
        rec_valid = 1'b1;
        tick(1);
        rec_valid = 1'b0;
        chk("R7 word kept while busy", word_out, exp_word(0));
        for (int i = 1; i < 4; i++) pump_step(i);
        drain(3);  // R7 still four words of the first record
    endtask

    task automatic t_pause();
        make_record(66);
        load_rec(3'd1);
        run_en = 1'b0;
        pump = 1'b1;
        tick(5);
        chk("R8 word frozen", word_out, exp_word(0));
        chk("R8 have_data frozen", 32'(have_data), 32'd1);
        pump = 1'b0;
        tick(4);
        run_en = 1'b1;
        tick(4);
        chk("R8 paused pump discarded", word_out, exp_word(0));
        for (int i = 1; i < 4; i++) pump_step(i);
        drain(3);
        run_en = 1'b0;
        rec_valid = 1'b1; rec_count = 3'd2;
        tick(1);
        rec_valid = 1'b0;
        tick(1);
        chk("R8 no load while paused", 32'(have_data), 32'd0);
        run_en = 1'b1;
        tick(2);
        chk("R8 no late load", 32'(have_data), 32'd0);
    endtask

    task automatic t_full();
        buf_full = 1'b1;
        #1;
        chk("R9 data_lost high", 32'(data_lost), 32'd1);
        buf_full = 1'b0;
        #1;
        chk("R9 data_lost low", 32'(data_lost), 32'd0);
    endtask

    initial begin
        tick(1);
        t_reset();
        for (int c = 1; c <= 6; c++) t_stream(3'(c), c * 17);
        t_stream(3'd7, 200);   // R4 clamp to six thresholds
        t_zero();
        t_busy();
        t_pause();
        t_full();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule